// File: doc/BRIEF.md
# Indirect-Window Interrupt Router Register Block

This block holds the programmable state of an interrupt router and exposes it to a bus master through only two directly addressed locations. The first is an 8-bit select register, at byte offset 0x00. The second is a 32-bit data window, at byte offset 0x10. The value in the select register chooses which internal register the window reaches. Behind the window are an identification register, a read-only version word, an arbitration word that mirrors the identification, and a redirection table with one 64-bit entry per input pin. Each table entry is accessed as two 32-bit halves.

Each table entry has a fixed layout:
- bits 7:0 hold the vector.
- bits 10:8 hold the delivery mode.
- bit 11 holds the destination mode.
- bit 14 is the remote-acknowledge-pending flag.
- bit 15 is the trigger mode (1 = level).
- bit 16 is the mask.
- bits 63:56 hold the destination ID.

The delivery logic sets the remote-acknowledge flag through a set port. It receives one-cycle strobes when a mask bit changes and when a table write leaves a level-triggered pin with its request asserted.

A bus access is a single-cycle request. Read data comes back with a valid flag on the following cycle. The strobes also appear one cycle after the write that causes them. The reset input is asynchronous and active low, and its release is synchronised inside the block over two clock edges.

Top module: `irq_router_regs`

## Requirements
- R1: Only byte offsets 0x00 (select) and 0x10 (window) are decoded. A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: A write to offset 0x00 keeps bits 7:0 of the data in the select register. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R3: With select = 0x01, the window reads PINS-1 in bits 23:16 and version code 0x11 in bits 7:0, with all other bits 0. Writes to it are ignored.
- R4: With select = 0x00, a window write stores data bits 27:24 as a 4-bit ID. Select 0x00 and select 0x02 both read the ID in bits 27:24, with all other bits 0. A write with select = 0x02 has no effect.
- R5: A select value s >= 0x10 addresses table entry (s-0x10)>>1. Even s reaches bits 31:0 of the entry and odd s reaches bits 63:32. Writes store the half and reads return it.
- R6: Select values 0x03 to 0x0F, and table indices >= PINS, read 0xFFFFFFFF. Writes to them change no entry.
- R7: A write of an entry's low half forces its bit 14 to 0, and a write of the high half leaves bit 14 unchanged. ack_set sets bit 14 of entry ack_pin. When ack_set and a low-half write hit the same entry in one cycle, bit 14 ends at 0.
- R8: When a table write changes an entry's bit 16, mask_evt is high for the one cycle after the write, with mask_evt_pin = the entry index and mask_evt_val = the new bit 16. A write that leaves bit 16 unchanged raises no strobe.
- R9: After any table write whose resulting entry has bit 15 = 1 while pin_req of that pin is 1, svc_req is high for the following cycle with svc_pin = the pin. This holds whatever the mask bit is.
- R10: After reset, every entry reads 0x00010000 (low half) and 0x00000000 (high half), and the select register and the ID read 0.
- R11: bus_rvalid is high exactly in the cycle after each read request, and bus_rdata carries the addressed word in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pin_req | input | PINS | Request level of each pin from the delivery logic |
| ack_set | input | 1 | Set the remote-acknowledge flag of entry ack_pin |
| ack_pin | input | IDX_W | Entry index for ack_set |
| mask_evt | output | 1 | Mask-change strobe |
| mask_evt_pin | output | IDX_W | Entry whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | 1 | Service request strobe |
| svc_pin | output | IDX_W | Pin to be serviced |

## Verification
One window write can raise the mask-change strobe and the service request in the same cycle. The bench provokes this by unmasking a level-triggered entry whose pin request is held high, and expects both strobes, each carrying the same pin, on the cycle after the write. A second collision drives ack_set on the same cycle as a low-half write to the same entry. The bench judges that case by reading the entry back and expecting bit 14 clear.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam int HALF_W = 32;
  localparam int ENT_W  = 2 * HALF_W;
  localparam int B_RACK = 14;
  localparam int B_TRIG = 15;
  localparam int B_MASK = 16;
  localparam logic [ENT_W-1:0] ENT_RST = ENT_W'(1) << B_MASK;

  typedef enum logic [1:0] {TGT_NONE, TGT_SEL, TGT_WIN} tgt_e;
  typedef enum logic [2:0] {WK_ID, WK_VER, WK_ARB, WK_TBL, WK_BAD} wkind_e;
endpackage

// File: rtl/irr_decode.sv
module irr_decode
  import irr_pkg::*;
#(
  parameter int PINS = 24,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] WIN_OFS = 'h10,
  localparam int IDX_W = $clog2(PINS)
) (
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        sel_q,
  output tgt_e              tgt,
  output wkind_e            wk,
  output logic              sel_we,
  output logic              win_we,
  output logic              rd_fire,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic              tbl_hi
);
  logic [6:0] idx_raw;

  always_comb begin
    if (bus_addr == SEL_OFS)      tgt = TGT_SEL;
    else if (bus_addr == WIN_OFS) tgt = TGT_WIN;
    else                          tgt = TGT_NONE;
  end

  assign idx_raw = sel_q[7:1] - 7'd8;
  assign tbl_idx = idx_raw[IDX_W-1:0];
  assign tbl_hi  = sel_q[0];

  always_comb begin
    case (sel_q)
      8'h00:   wk = WK_ID;
      8'h01:   wk = WK_VER;
      8'h02:   wk = WK_ARB;
      default: wk = (sel_q >= 8'h10 && int'(idx_raw) < PINS) ? WK_TBL : WK_BAD;
    endcase
  end

  assign sel_we  = bus_req && bus_we && (tgt == TGT_SEL);
  assign win_we  = bus_req && bus_we && (tgt == TGT_WIN);
  assign rd_fire = bus_req && !bus_we;
endmodule

// File: rtl/irr_table.sv
module irr_table
  import irr_pkg::*;
#(
  parameter int PINS = 24,
  localparam int IDX_W = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [HALF_W-1:0] wdata,
  input  logic              ack_set,
  input  logic [IDX_W-1:0]  ack_pin,
  input  logic              rd_hi,
  output logic [HALF_W-1:0] rd_half,
  output logic [ENT_W-1:0]  wr_old,
  output logic [ENT_W-1:0]  wr_new
);
  logic [ENT_W-1:0] ent_q [PINS];
  logic [ENT_W-1:0] ent_d [PINS];

  for (genvar g = 0; g < PINS; g++) begin : g_ent
    logic [ENT_W-1:0] q, d;
    logic             wr_hit, ack_hit, en;

    assign wr_hit  = wr_en && (wr_idx == IDX_W'(g));
    assign ack_hit = ack_set && (ack_pin == IDX_W'(g));
    assign en      = wr_hit || ack_hit;

    always_comb begin
      d = q;
      if (ack_hit) d[B_RACK] = 1'b1;
      if (wr_hit) begin
        if (wr_hi) d[ENT_W-1:HALF_W] = wdata;
        else begin
          d[HALF_W-1:0] = wdata;
          d[B_RACK]     = 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= ENT_RST;
      else if (en) q <= d;
    end

    assign ent_q[g] = q;
    assign ent_d[g] = d;
  end

  always_comb begin
    rd_half = '1;
    wr_old  = '0;
    wr_new  = '0;
    if (int'(wr_idx) < PINS) begin
      rd_half = rd_hi ? ent_q[wr_idx][ENT_W-1:HALF_W] : ent_q[wr_idx][HALF_W-1:0];
      wr_old  = ent_q[wr_idx];
      wr_new  = ent_d[wr_idx];
    end
  end
endmodule

// File: rtl/irr_events.sv
module irr_events
  import irr_pkg::*;
#(
  parameter int PINS = 24,
  localparam int IDX_W = $clog2(PINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_old,
  input  logic [ENT_W-1:0] wr_new,
  input  logic [PINS-1:0]  pin_req,
  output logic             mask_evt,
  output logic [IDX_W-1:0] mask_evt_pin,
  output logic             mask_evt_val,
  output logic             svc_req,
  output logic [IDX_W-1:0] svc_pin
);
  logic mchg_d, svc_d, req_bit;

  assign req_bit = (int'(wr_idx) < PINS) ? pin_req[wr_idx] : 1'b0;
  assign mchg_d  = wr_en && (wr_old[B_MASK] != wr_new[B_MASK]);
  assign svc_d   = wr_en && wr_new[B_TRIG] && req_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_evt <= 1'b0;
      svc_req  <= 1'b0;
    end else begin
      mask_evt <= mchg_d;
      svc_req  <= svc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_evt_pin <= '0;
      mask_evt_val <= 1'b0;
    end else if (mchg_d) begin
      mask_evt_pin <= wr_idx;
      mask_evt_val <= wr_new[B_MASK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     svc_pin <= '0;
    else if (svc_d) svc_pin <= wr_idx;
  end
endmodule

// File: rtl/irr_rdmux.sv
module irr_rdmux
  import irr_pkg::*;
#(
  parameter int PINS = 24,
  parameter logic [7:0] VER_CODE = 8'h11
) (
  input  tgt_e              tgt,
  input  wkind_e            wk,
  input  logic [7:0]        sel_q,
  input  logic [3:0]        id_q,
  input  logic [HALF_W-1:0] tbl_half,
  output logic [HALF_W-1:0] word
);
  localparam logic [HALF_W-1:0] VER_WORD = {8'h00, 8'(PINS - 1), 8'h00, VER_CODE};

  always_comb begin
    word = '0;
    case (tgt)
      TGT_SEL: word = {24'h0, sel_q};
      TGT_WIN: begin
        case (wk)
          WK_ID, WK_ARB: word = {4'h0, id_q, 24'h0};
          WK_VER:        word = VER_WORD;
          WK_TBL:        word = tbl_half;
          default:       word = '1;
        endcase
      end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/irq_router_regs.sv
module irq_router_regs
  import irr_pkg::*;
#(
  parameter int PINS = 24,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] WIN_OFS = 'h10,
  parameter logic [7:0] VER_CODE = 8'h11,
  localparam int IDX_W = $clog2(PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [PINS-1:0]   pin_req,
  input  logic              ack_set,
  input  logic [IDX_W-1:0]  ack_pin,
  output logic              mask_evt,
  output logic [IDX_W-1:0]  mask_evt_pin,
  output logic              mask_evt_val,
  output logic              svc_req,
  output logic [IDX_W-1:0]  svc_pin
);
  logic             rs1_q, rst_sync_n;
  logic [7:0]       sel_q, sel_d;
  logic [3:0]       id_q, id_d;
  logic             id_we;
  tgt_e             tgt;
  wkind_e           wk;
  logic             sel_we, win_we, rd_fire, tbl_hi, tbl_we;
  logic [IDX_W-1:0] tbl_idx;
  logic [31:0]      tbl_half, rd_word;
  logic [ENT_W-1:0] wr_old, wr_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rs1_q      <= 1'b1;
      rst_sync_n <= rs1_q;
    end
  end

  irr_decode #(.PINS(PINS), .ADDR_W(ADDR_W), .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS)) u_dec (
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .sel_q(sel_q),
    .tgt(tgt), .wk(wk), .sel_we(sel_we), .win_we(win_we), .rd_fire(rd_fire),
    .tbl_idx(tbl_idx), .tbl_hi(tbl_hi)
  );

  assign tbl_we = win_we && (wk == WK_TBL);
  assign id_we  = win_we && (wk == WK_ID);
  assign sel_d  = bus_wdata[7:0];
  assign id_d   = bus_wdata[27:24];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  sel_q <= '0;
    else if (sel_we)  sel_q <= sel_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) id_q <= '0;
    else if (id_we)  id_q <= id_d;
  end

  irr_table #(.PINS(PINS)) u_tbl (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(tbl_we), .wr_hi(tbl_hi), .wr_idx(tbl_idx),
    .wdata(bus_wdata), .ack_set(ack_set), .ack_pin(ack_pin), .rd_hi(tbl_hi),
    .rd_half(tbl_half), .wr_old(wr_old), .wr_new(wr_new)
  );

  irr_events #(.PINS(PINS)) u_evt (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(tbl_we), .wr_idx(tbl_idx),
    .wr_old(wr_old), .wr_new(wr_new), .pin_req(pin_req),
    .mask_evt(mask_evt), .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val),
    .svc_req(svc_req), .svc_pin(svc_pin)
  );

  irr_rdmux #(.PINS(PINS), .VER_CODE(VER_CODE)) u_rd (
    .tgt(tgt), .wk(wk), .sel_q(sel_q), .id_q(id_q), .tbl_half(tbl_half), .word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) bus_rvalid <= 1'b0;
    else             bus_rvalid <= rd_fire;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  bus_rdata <= '0;
    else if (rd_fire) bus_rdata <= rd_word;
  end
endmodule

// File: rtl/irr_checker.sv
module irr_checker #(
  parameter int PINS = 24,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] SEL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] WIN_OFS = 'h10,
  localparam int IDX_W = $clog2(PINS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              mask_evt,
  input logic              svc_req
);
  assert_rvalid_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  assert_no_stray_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && !bus_we) |=> !bus_rvalid);

  assert_undecoded_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr != SEL_OFS && bus_addr != WIN_OFS) |=> (bus_rdata == 32'h0));

  assert_select_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr == SEL_OFS) ##1 (bus_req && !bus_we && bus_addr == SEL_OFS)
    |=> (bus_rdata == {24'h0, $past(bus_wdata[7:0], 2)}));

  assert_mask_evt_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mask_evt |-> $past(bus_req && bus_we && bus_addr == WIN_OFS));

  assert_svc_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_req |-> $past(bus_req && bus_we && bus_addr == WIN_OFS));
endmodule

bind irq_router_regs irr_checker #(.PINS(PINS), .ADDR_W(ADDR_W), .SEL_OFS(SEL_OFS), .WIN_OFS(WIN_OFS)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
  .mask_evt(mask_evt), .svc_req(svc_req)
);

// File: tb/sim_irq_router_regs.sv
module sim_irq_router_regs;
  localparam int PINS = 24;
  localparam int IDX_W = $clog2(PINS);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             bus_req, bus_we;
  logic [7:0]       bus_addr;
  logic [31:0]      bus_wdata, bus_rdata;
  logic             bus_rvalid;
  logic [PINS-1:0]  pin_req;
  logic             ack_set;
  logic [IDX_W-1:0] ack_pin;
  logic             mask_evt, mask_evt_val, svc_req;
  logic [IDX_W-1:0] mask_evt_pin, svc_pin;

  always #5 clk = ~clk;

  irq_router_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .pin_req(pin_req), .ack_set(ack_set), .ack_pin(ack_pin),
    .mask_evt(mask_evt), .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val),
    .svc_req(svc_req), .svc_pin(svc_pin)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] m_ent [PINS];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic [31:0] q_exp [$];
  string       q_tag [$];

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    int i;
    if (a == 8'h00) return {24'h0, m_sel};
    if (a != 8'h10) return 32'h0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h00, 8'(PINS - 1), 8'h00, 8'h11};
    i = (int'(m_sel) - 16) / 2;
    if (m_sel < 8'h10 || i >= PINS) return 32'hFFFF_FFFF;
    return m_sel[0] ? m_ent[i][63:32] : m_ent[i][31:0];
  endfunction

  // monitor: pops expected read words as they come back
  initial begin
    forever begin
      @(negedge clk);
      if (bus_rvalid === 1'b1) begin
        if (q_exp.size() == 0) check(1'b0, "R11 unexpected rvalid", bus_rdata, 0);
        else begin
          automatic logic [31:0] e = q_exp.pop_front();
          automatic string t = q_tag.pop_front();
          check(bus_rdata === e, t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    q_exp.push_back(exp_read(a));
    q_tag.push_back(tag);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  // write with model update; ack_now drives ack_set in the same cycle
  task automatic bus_wr_ack(input logic [7:0] a, input logic [31:0] d, input bit ack_now,
                            input int ack_i, input string tag);
    bit em = 0, es = 0, ev = 0;
    int ei = 0;
    @(negedge clk);
    if (ack_now) m_ent[ack_i][14] = 1'b1;
    if (a == 8'h00) m_sel = d[7:0];
    else if (a == 8'h10) begin
      if (m_sel == 8'h00) m_id = d[27:24];
      else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < PINS) begin
        automatic logic [63:0] old;
        ei = (int'(m_sel) - 16) / 2;
        old = m_ent[ei];
        if (m_sel[0]) m_ent[ei][63:32] = d;
        else begin m_ent[ei][31:0] = d; m_ent[ei][14] = 1'b0; end
        em = (old[16] != m_ent[ei][16]);
        ev = m_ent[ei][16];
        es = m_ent[ei][15] && pin_req[ei];
      end
    end
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    ack_set = ack_now; ack_pin = IDX_W'(ack_i);
    @(negedge clk);
    bus_req = 1'b0; ack_set = 1'b0;
    check(mask_evt === em, {tag, " R8 mask_evt"}, 64'(mask_evt), 64'(em));
    if (em) check(mask_evt_pin === IDX_W'(ei) && mask_evt_val === ev, {tag, " R8 pin/val"},
                  {mask_evt_pin, mask_evt_val}, {IDX_W'(ei), ev});
    check(svc_req === es, {tag, " R9 svc_req"}, 64'(svc_req), 64'(es));
    if (es) check(svc_pin === IDX_W'(ei), {tag, " R9 svc_pin"}, 64'(svc_pin), 64'(ei));
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    bus_wr_ack(a, d, 1'b0, 0, tag);
  endtask

  task automatic ack(input int i);
    @(negedge clk);
    ack_set = 1'b1; ack_pin = IDX_W'(i);
    m_ent[i][14] = 1'b1;
    @(negedge clk);
    ack_set = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pin_req = '0; ack_set = 1'b0; ack_pin = '0;
    for (int i = 0; i < PINS; i++) m_ent[i] = 64'h0000_0000_0001_0000;
    m_sel = '0; m_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check(bus_rvalid === 1'b0 && mask_evt === 1'b0 && svc_req === 1'b0, "R10 idle outputs", 0, 0);
    bus_rd(8'h00, "R10 select reset");
    bus_rd(8'h10, "R10 id reset");
    bus_wr(8'h00, 32'h10, "R10");
    bus_rd(8'h10, "R10 entry0 low");
    bus_wr(8'h00, 32'h11, "R10");
    bus_rd(8'h10, "R10 entry0 high");
    bus_wr(8'h00, 32'h3E, "R10");
    bus_rd(8'h10, "R10 entry23 low");

    // R2 select width and readback
    bus_wr(8'h00, 32'h1234_56A5, "R2");
    bus_rd(8'h00, "R2 select low byte");
    bus_rd(8'h10, "R6 index 74 all ones");

    // R3 version
    bus_wr(8'h00, 32'h01, "R3");
    bus_rd(8'h10, "R3 version word");
    bus_wr(8'h10, 32'hFFFF_FFFF, "R3");
    bus_rd(8'h10, "R3 version after write");

    // R4 id and arbitration
    bus_wr(8'h00, 32'h00, "R4");
    bus_wr(8'h10, 32'hF5A5_5A5A, "R4");
    bus_rd(8'h10, "R4 id readback");
    bus_wr(8'h00, 32'h02, "R4");
    bus_rd(8'h10, "R4 arb mirrors id");
    bus_wr(8'h10, 32'h0C00_0000, "R4");
    bus_rd(8'h10, "R4 arb write ignored");

    // R1 undecoded offsets
    bus_wr(8'h08, 32'h0000_0033, "R1");
    bus_rd(8'h00, "R1 select unchanged");
    bus_rd(8'h04, "R1 offset 4 reads zero");
    bus_rd(8'h20, "R1 offset 0x20 reads zero");

    // R5 table halves, R8 unmask strobe
    bus_wr(8'h00, 32'h14, "R5");
    bus_wr(8'h10, 32'h0000_0A31, "R5 low write");
    bus_rd(8'h10, "R5 entry2 low");
    bus_wr(8'h00, 32'h15, "R5");
    bus_wr(8'h10, 32'hC300_0000, "R5 high write");
    bus_rd(8'h10, "R5 entry2 high");

    // R6 out of range
    bus_wr(8'h00, 32'h40, "R6");
    bus_wr(8'h10, 32'h0000_0000, "R6 write beyond table");
    bus_rd(8'h10, "R6 index 24");
    bus_wr(8'h00, 32'h0F, "R6");
    bus_rd(8'h10, "R6 select 0x0F");
    bus_wr(8'h00, 32'h03, "R6");
    bus_rd(8'h10, "R6 select 0x03");
    bus_wr(8'h00, 32'h3F, "R6");
    bus_rd(8'h10, "R6 entry23 high untouched");

    // R7 remote-acknowledge flag
    ack(2);
    bus_wr(8'h00, 32'h14, "R7");
    bus_rd(8'h10, "R7 ack set visible");
    bus_wr(8'h00, 32'h15, "R7");
    bus_wr(8'h10, 32'hC400_0000, "R7 high write");
    bus_wr(8'h00, 32'h14, "R7");
    bus_rd(8'h10, "R7 high write keeps flag");
    bus_wr(8'h10, 32'h0000_4A31, "R7 low write");
    bus_rd(8'h10, "R7 low write clears flag");
    bus_wr_ack(8'h10, 32'h0000_0A32, 1'b1, 2, "R7 collision");
    bus_rd(8'h10, "R7 collision write wins");

    // R8 mask strobes
    bus_wr(8'h10, 32'h0001_0A32, "R8 mask set");
    bus_wr(8'h10, 32'h0001_0A33, "R8 mask unchanged");
    bus_wr(8'h00, 32'h1F, "R8");
    bus_wr(8'h10, 32'h1100_0000, "R8 high half no change");

    // R9 service requests
    pin_req = '0;
    pin_req[9] = 1'b1; pin_req[10] = 1'b1; pin_req[11] = 1'b1;
    bus_wr(8'h00, 32'h22, "R9");
    bus_wr(8'h10, 32'h0000_8040, "R9 level unmask both strobes");
    bus_wr(8'h00, 32'h23, "R9");
    bus_wr(8'h10, 32'h0200_0000, "R9 high half re-eval");
    pin_req[9] = 1'b0;
    bus_wr(8'h10, 32'h0300_0000, "R9 request low");
    bus_wr(8'h00, 32'h24, "R9");
    bus_wr(8'h10, 32'h0000_0041, "R9 edge no service");
    bus_wr(8'h00, 32'h26, "R9");
    bus_wr(8'h10, 32'h0001_8042, "R9 masked level still serviced");
    bus_rd(8'h10, "R5 entry11 low");

    repeat (3) @(negedge clk);
    check(q_exp.size() == 0, "R11 all reads returned", 64'(q_exp.size()), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule